// File: doc/BRIEF.md
# Dual-Target Interrupt Priority Decoder

This block sorts a set of level-sensitive interrupt request channels between two consumers: the main CPU and a coprocessor. Each channel has a 3-bit priority level and a routing bit. Channels routed to the coprocessor go through a coprocessor decoder. That decoder picks the strongest pending request and hands it over with a one-bit urgency tag. It does not look at what the coprocessor is running; the coprocessor makes its own preemption decisions.

Channels routed to the CPU go through a CPU decoder. The CPU decoder raises an interrupt line when the best pending level is above the CPU's current mask. The coprocessor can also raise CPU interrupts through per-channel flags. All of these share one programmable priority. The CPU vector is not fixed when the line rises. It is computed at the moment the CPU asks for it. If a stronger request has arrived by then, it takes the place of the earlier one. If nothing eligible is left, a fixed spurious vector is returned.

The vector path is a two-state machine. In `VS_IDLE` it waits. A vector-request pulse moves it to `VS_DELIVER` and latches the resolved vector at the same edge. In `VS_DELIVER` the valid strobe is high for that cycle. A further request pulse keeps it in `VS_DELIVER` with a freshly resolved vector. Otherwise it returns to `VS_IDLE`.

Top module: `irq_dual_decoder`

## Requirements
- R1: A channel with routing bit 1 is a candidate only for the coprocessor decoder, and its request line never drives the CPU decoder. A channel with routing bit 0 is a candidate only for the CPU decoder.
- R2: A channel whose effective level is 0 never wins in either decoder.
- R3: `cop_req` is high when at least one coprocessor-routed channel is requesting with a nonzero level. `cop_id` is then the channel with the highest level, and ties go to the higher channel index. The choice does not depend on `cpu_mask`.
- R4: `cop_urgent` equals bit 2 of the winning coprocessor channel's level. It is 1 for levels 4 to 7.
- R5: `cpu_irq` is high exactly when the best CPU candidate level is strictly greater than `cpu_mask`.
- R6: Among CPU candidates, the highest level wins and equal levels go to the higher channel index, which is also the higher vector address. The vector for channel i is `vec_base + 2*i`, computed modulo 2^VEC_W.
- R7: After a one-cycle `vec_req` pulse, `vec_valid` is high for exactly the next cycle. `vec_out` then holds the vector resolved from the inputs present at that request edge, so a request raised after `cpu_irq` but before the edge wins.
- R8: If no CPU candidate is above `cpu_mask` at the request edge, `vec_out` is the parameter `SPURIOUS_VEC`.
- R9: Coprocessor-raised flag i is a CPU candidate at level `cop_prio` only when `cop_ie` is 1 and channel i's routing bit is 1. Its vector is `vec_base + 2*i`.
- R10: During and right after reset, `vec_valid` is 0 and `vec_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | NUM_CH | Level-sensitive request per channel |
| chan_level | input | 3*NUM_CH | Priority level per channel, channel i at bits [3i+2:3i] |
| chan_route | input | NUM_CH | 1 routes the channel to the coprocessor |
| cop_flags | input | NUM_CH | Coprocessor-raised CPU interrupt flags |
| cop_ie | input | 1 | Global enable for coprocessor-raised interrupts |
| cop_prio | input | 3 | Shared level of coprocessor-raised interrupts |
| cpu_mask | input | 3 | Current CPU interrupt mask level |
| vec_base | input | VEC_W | Vector table base address |
| vec_req | input | 1 | CPU vector request pulse |
| cpu_irq | output | 1 | CPU interrupt line |
| vec_valid | output | 1 | Vector strobe, one cycle after `vec_req` |
| vec_out | output | VEC_W | Resolved CPU vector |
| cop_req | output | 1 | Coprocessor request present |
| cop_id | output | ID_W | Winning coprocessor channel |
| cop_urgent | output | 1 | Urgency tag, MSB of the winning level |

## Verification
The bench builds the block with NUM_CH = 4 and VEC_W = 16. At that size every combination of the 12 level bits is driven. Request, routing, flag, enable, shared-priority and mask patterns are derived arithmetically from the sweep index, so both decoders see mixed routings, ties, zero levels and all mask values. The small channel count also makes timed scenarios easy to stage: a stronger request arriving between the interrupt line and the vector fetch, and a request that drops before the fetch.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef enum logic {
        VS_IDLE    = 1'b0,
        VS_DELIVER = 1'b1
    } vec_state_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick
    import irq_pkg::*;
#(
    parameter int N    = 8,
    parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*LVL_W-1:0] lvls,
    output logic               found,
    output logic [ID_W-1:0]    win_id,
    output lvl_t               win_lvl
);
    // Linear scan: ">=" makes the later (higher index) channel win ties.
    always_comb begin
        win_lvl = '0;
        win_id  = '0;
        for (int i = 0; i < N; i++) begin
            if (lvls[i*LVL_W +: LVL_W] != '0 && lvls[i*LVL_W +: LVL_W] >= win_lvl) begin
                win_lvl = lvls[i*LVL_W +: LVL_W];
                win_id  = ID_W'(i);
            end
        end
        found = (win_lvl != '0);
    end
endmodule

// File: rtl/vec_fsm.sv
module vec_fsm
    import irq_pkg::*;
#(
    parameter int          ID_W         = 3,
    parameter int          VEC_W        = 16,
    parameter logic [15:0] SPURIOUS_VEC = 16'hFFF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_req,
    input  logic             cand_found,
    input  lvl_t             cand_lvl,
    input  logic [ID_W-1:0]  cand_id,
    input  lvl_t             cpu_mask,
    input  logic [VEC_W-1:0] vec_base,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);
    vec_state_e state_q, state_d;
    logic       eligible;
    logic [VEC_W-1:0] resolved;

    assign eligible = cand_found && (cand_lvl > cpu_mask);
    assign resolved = eligible ? (vec_base + (VEC_W'(cand_id) << 1))
                               : VEC_W'(SPURIOUS_VEC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE:    state_d = vec_req ? VS_DELIVER : VS_IDLE;
            VS_DELIVER: state_d = vec_req ? VS_DELIVER : VS_IDLE;
            default:    state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_IDLE;
        else        state_q <= state_d;
    end

    // Output process: vector is bound only at the request edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec_out <= '0;
        else if (vec_req) vec_out <= resolved;
    end

    assign vec_valid = (state_q == VS_DELIVER);

    assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> vec_valid);
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> !vec_valid);
    assert_spurious_when_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !(cand_found && cand_lvl > cpu_mask)) |=> (vec_out == VEC_W'(SPURIOUS_VEC)));
endmodule

// File: rtl/irq_dual_decoder.sv
module irq_dual_decoder
    import irq_pkg::*;
#(
    parameter int          NUM_CH       = 8,
    parameter int          VEC_W        = 16,
    parameter logic [15:0] SPURIOUS_VEC = 16'hFFF0,
    localparam int         ID_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       chan_req,
    input  logic [3*NUM_CH-1:0]     chan_level,
    input  logic [NUM_CH-1:0]       chan_route,
    input  logic [NUM_CH-1:0]       cop_flags,
    input  logic                    cop_ie,
    input  logic [2:0]              cop_prio,
    input  logic [2:0]              cpu_mask,
    input  logic [VEC_W-1:0]        vec_base,
    input  logic                    vec_req,
    output logic                    cpu_irq,
    output logic                    vec_valid,
    output logic [VEC_W-1:0]        vec_out,
    output logic                    cop_req,
    output logic [ID_W-1:0]         cop_id,
    output logic                    cop_urgent
);
    logic [NUM_CH*LVL_W-1:0] cpu_lvls, cop_lvls;
    logic                    cpu_found;
    logic [ID_W-1:0]         cpu_id;
    lvl_t                    cpu_lvl, cop_lvl;

    // Effective level per channel for each target.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_route
        always_comb begin
            if (chan_route[g]) begin
                cop_lvls[g*LVL_W +: LVL_W] = chan_req[g] ? chan_level[g*LVL_W +: LVL_W] : '0;
                cpu_lvls[g*LVL_W +: LVL_W] = (cop_ie && cop_flags[g]) ? cop_prio : '0;
            end else begin
                cop_lvls[g*LVL_W +: LVL_W] = '0;
                cpu_lvls[g*LVL_W +: LVL_W] = chan_req[g] ? chan_level[g*LVL_W +: LVL_W] : '0;
            end
        end
    end

    prio_pick #(.N(NUM_CH), .ID_W(ID_W)) u_cpu_pick (
        .lvls(cpu_lvls), .found(cpu_found), .win_id(cpu_id), .win_lvl(cpu_lvl)
    );

    prio_pick #(.N(NUM_CH), .ID_W(ID_W)) u_cop_pick (
        .lvls(cop_lvls), .found(cop_req), .win_id(cop_id), .win_lvl(cop_lvl)
    );

    assign cop_urgent = cop_req && cop_lvl[LVL_W-1];
    assign cpu_irq    = cpu_found && (cpu_lvl > cpu_mask);

    vec_fsm #(.ID_W(ID_W), .VEC_W(VEC_W), .SPURIOUS_VEC(SPURIOUS_VEC)) u_vec (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req),
        .cand_found(cpu_found), .cand_lvl(cpu_lvl), .cand_id(cpu_id),
        .cpu_mask(cpu_mask), .vec_base(vec_base),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    assert_cop_routed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cop_req |-> (chan_route[cop_id] && chan_req[cop_id]));
    assert_cop_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cop_req |-> (chan_level[cop_id*LVL_W +: LVL_W] != 3'd0));
    assert_urgent_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cop_req |-> (cop_urgent == chan_level[cop_id*LVL_W + 2]));
    assert_quiet_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((chan_req & ~chan_route) == '0) && (!cop_ie || (cop_flags & chan_route) == '0)) |-> !cpu_irq);
endmodule

// File: tb/irq_dual_decoder_tb.sv
module irq_dual_decoder_tb;
    localparam int N = 4;
    localparam int VW = 16;
    localparam logic [15:0] SPUR = 16'hFFF0;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] chan_req = 0, chan_route = 0, cop_flags = 0;
    logic [3*N-1:0] chan_level = 0;
    logic cop_ie = 0, vec_req = 0;
    logic [2:0] cop_prio = 0, cpu_mask = 0;
    logic [VW-1:0] vec_base = 16'hFF00;
    logic cpu_irq, vec_valid, cop_req, cop_urgent;
    logic [VW-1:0] vec_out;
    logic [1:0] cop_id;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // expected values
    bit e_irq, e_cop_req, e_urg;
    int e_cop_id;
    logic [VW-1:0] e_vec;

    irq_dual_decoder #(.NUM_CH(N), .VEC_W(VW), .SPURIOUS_VEC(SPUR)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_level(chan_level),
        .chan_route(chan_route), .cop_flags(cop_flags), .cop_ie(cop_ie),
        .cop_prio(cop_prio), .cpu_mask(cpu_mask), .vec_base(vec_base),
        .vec_req(vec_req), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
        .vec_out(vec_out), .cop_req(cop_req), .cop_id(cop_id), .cop_urgent(cop_urgent)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model, from the requirements.
    task automatic model();
        int bl_cpu, bl_cop, bi_cpu;
        bl_cpu = 0; bl_cop = 0; bi_cpu = 0; e_cop_id = 0;
        for (int i = 0; i < N; i++) begin
            int l, lc;
            l = chan_level[3*i +: 3];
            if (chan_route[i]) begin
                lc = (cop_ie && cop_flags[i]) ? int'(cop_prio) : 0;
                if (chan_req[i] && l > 0 && l >= bl_cop) begin bl_cop = l; e_cop_id = i; end
            end else begin
                lc = chan_req[i] ? l : 0;
            end
            if (lc > 0 && lc >= bl_cpu) begin bl_cpu = lc; bi_cpu = i; end
        end
        e_cop_req = (bl_cop > 0);
        e_urg = (bl_cop >= 4);
        e_irq = (bl_cpu > int'(cpu_mask));
        e_vec = e_irq ? VW'(int'(vec_base) + 2*bi_cpu) : SPUR;
        if (!e_cop_req) e_cop_id = 0;
    endtask

    // Pulse vec_req for one cycle starting at a negedge; check at following negedge.
    task automatic fetch_and_check(input string req);
        vec_req = 1;
        @(negedge clk);
        vec_req = 0;
        chk({req, " valid"}, vec_valid, 1);
        chk({req, " vector"}, vec_out, e_vec);
    endtask

    initial begin
        @(negedge clk);
        // R10 reset state
        chk("R10 valid in reset", vec_valid, 0);
        chk("R10 vec_out in reset", vec_out, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R10 valid after reset", vec_valid, 0);
        chk("R10 vec_out after reset", vec_out, 0);

        // R2: level 0 request never wins
        chan_req = 4'b0001; chan_level = 12'h000; cpu_mask = 0; #1;
        chk("R2 level0 cpu_irq", cpu_irq, 0);
        chan_route = 4'b0001; #1;
        chk("R2 level0 cop_req", cop_req, 0);
        chan_route = 0;

        // R7: late binding - stronger request arrives before fetch
        @(negedge clk);
        chan_req = 4'b0001; chan_level = 12'h002;   // ch0 level 2
        @(negedge clk);
        chk("R5 irq raised", cpu_irq, 1);
        chan_req = 4'b0011; chan_level = 12'h02A;   // ch1 level 5
        model();
        chk("R7 late model sanity", e_vec, 16'hFF02);
        fetch_and_check("R7 late binding");
        @(negedge clk);
        chk("R7 valid drops", vec_valid, 0);

        // R8: request drops between recognition and fetch
        chan_req = 0; model();
        fetch_and_check("R8 dropped request spurious");
        @(negedge clk);

        // R6: tie resolved to higher index
        chan_req = 4'b1001; chan_level = 12'h603; cpu_mask = 1; // ch0=3, ch3=3
        model();
        fetch_and_check("R6 tie higher vector");
        @(negedge clk);

        // R9: flag without enable is ignored, with enable wins
        chan_req = 0; chan_route = 4'b0100; cop_flags = 4'b0100; cop_prio = 3'd6;
        cop_ie = 0; cpu_mask = 0; #1;
        chk("R9 flag disabled no irq", cpu_irq, 0);
        cop_ie = 1; #1; model();
        chk("R9 flag enabled irq", cpu_irq, 1);
        fetch_and_check("R9 flag vector");
        @(negedge clk);

        // Sweep every level combination with derived controls.
        for (int k = 0; k < 4096; k++) begin
            chan_level = 12'(k);
            chan_req   = 4'((k * 5) ^ (k >> 4));
            chan_route = 4'((k >> 2) ^ (k >> 7));
            cop_flags  = 4'((k * 3) >> 1);
            cop_ie     = k[5] ^ k[9];
            cop_prio   = 3'(k >> 3);
            cpu_mask   = 3'((k >> 6) ^ k);
            vec_base   = 16'(16'hFF00 + (k & 16'h0F) * 16'h20);
            #1; model();
            chk("R1 R3 cop_req", cop_req, e_cop_req);
            if (e_cop_req) begin
                chk("R3 cop_id", cop_id, e_cop_id);
                chk("R4 cop_urgent", cop_urgent, e_urg);
            end
            chk("R5 R9 cpu_irq", cpu_irq, e_irq);
            fetch_and_check("R6 R8 sweep");
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule